// File: doc/BRIEF.md
# Sampled Shadow-Tag Contention Detector

This block watches the access stream of a shared last-level cache on behalf of one application, the owner. For a sampled fraction of the cache sets it keeps a private copy of the tags that the owner would hold if it had the whole cache to itself. When the owner misses in the shared cache but the private copy still holds the line, the miss happened only because other applications pushed the owner's line out. That is a contention miss.

Each contention miss raises a one-cycle pulse and adds to an interval counter. The counter tracks sampled sets only, so its output is scaled by the inverse of the sampling ratio and estimates the count over the whole cache. A slowdown estimator multiplies this count by an average miss service time and subtracts the product from the cycles the owner spent at high memory priority. An interval strobe clears the count at the start of each measurement window.

Top module: `ctn_shadow_detector`

## Requirements
- R1: After reset, `cont_pulse` is 0, `cont_count` is 0 and every shadow way is empty.
- R2: An access with `acc_valid`=1 from the owner (`acc_app` equal to parameter `OWNER_APP`) to a sampled set, with `acc_shared_hit`=0 and its tag present in the shadow store, raises `cont_pulse` for exactly the following cycle. Any other access gives no pulse. The address splits into a line offset of `OFF_W` bits, then a set index of `SET_W` bits, then the tag in the top bits.
- R3: A shared-cache hit never counts as contention, even when the shadow store holds the tag.
- R4: Accesses from other applications and accesses to unsampled sets cause no pulse and leave the shadow store unchanged. A set is sampled when its low `SAMP_W` index bits equal `SAMP_PAT`. The shadow row is the remaining upper index bits.
- R5: Each shadow row has `WAYS` ways with true LRU replacement. It is updated by every sampled owner access, hit or miss. On a shadow miss the least recently used tag is replaced.
- R6: `cont_count` equals the internal contention count shifted left by `SAMP_W` bits. It becomes valid in the same cycle as the pulse.
- R7: `interval_start` clears the count. If a contention miss occurs in the same cycle as the strobe, the new interval starts at one event, so the output shows 2^`SAMP_W`.
- R8: The internal count saturates at its all-ones value of `CNT_W` bits and does not wrap.
- R9: A cycle with `acc_valid`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_app | input | APP_W | Application issuing the access |
| acc_shared_hit | input | 1 | Outcome in the shared cache, 1 = hit |
| interval_start | input | 1 | Clears the count for a new interval |
| cont_pulse | output | 1 | One-cycle contention-miss indication |
| cont_count | output | CNT_W+SAMP_W | Scaled contention count for the interval |

## Verification
The interval strobe and a contention miss can land in the same cycle. The counter must then restart at one event, not at zero, and must not add to the old value. The bench forces this collision in a directed step after a known tag has been placed in the shadow row. It also raises the strobe at random during the random phase. After every access it compares pulse and count with a reference model. The model keeps its own LRU lists for each row, applies clear before increment, and expects 2^`SAMP_W` after a colliding strobe.

// File: rtl/ctn_pkg.sv
package ctn_pkg;

   // ceiling log2 with a floor of one bit, used for way and age fields
   function automatic int unsigned idx_bits(input int unsigned n);
      int unsigned b;
      b = 0;
      while ((1 << b) < n) b++;
      return (b == 0) ? 1 : b;
   endfunction

endpackage

// File: rtl/ctn_addr_split.sv
module ctn_addr_split
   import ctn_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int OFF_W    = 6,
   parameter int SET_W    = 10,
   parameter int SAMP_W   = 5,
   parameter int SAMP_PAT = 3,
   localparam int TAG_W   = ADDR_W - OFF_W - SET_W,
   localparam int ROW_W   = SET_W - SAMP_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [TAG_W-1:0]  tag,
   output logic [ROW_W-1:0]  row,
   output logic              sampled
);

   logic [SET_W-1:0] set_idx;
   logic             unused_offset;

   assign set_idx       = addr[OFF_W +: SET_W];
   assign tag           = addr[ADDR_W-1 -: TAG_W];
   assign row           = set_idx[SET_W-1 -: ROW_W];
   assign unused_offset = ^addr[OFF_W-1:0];

   generate
      if (SAMP_W == 0) begin : g_all_sets
         assign sampled = 1'b1;
      end else begin : g_subset
         assign sampled = (set_idx[SAMP_W-1:0] == SAMP_W'(SAMP_PAT));
      end
   endgenerate

endmodule

// File: rtl/ctn_shadow_tags.sv
module ctn_shadow_tags
   import ctn_pkg::*;
#(
   parameter int TAG_W  = 16,
   parameter int ROW_W  = 5,
   parameter int WAYS   = 4,
   localparam int ROWS  = 1 << ROW_W,
   localparam int WAY_W = idx_bits(WAYS),
   localparam int AGE_W = idx_bits(WAYS),
   localparam int SLOT_W = TAG_W + 1 + AGE_W,
   localparam int SNAP_W = ROWS * WAYS * SLOT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ROW_W-1:0] lk_row,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic             upd_en,
   output logic             lk_hit
);

   logic [TAG_W-1:0] tag_q   [ROWS][WAYS];
   logic             valid_q [ROWS][WAYS];
   logic [AGE_W-1:0] age_q   [ROWS][WAYS];

   logic [WAYS-1:0]  hit_vec;
   logic [WAY_W-1:0] hit_way;
   logic [WAY_W-1:0] victim_way;
   logic [WAY_W-1:0] touch_way;

   // associative lookup in the addressed row
   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         hit_vec[w] = valid_q[lk_row][w] && (tag_q[lk_row][w] == lk_tag);
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end

   assign lk_hit    = |hit_vec;
   assign touch_way = lk_hit ? hit_way : victim_way;

   // tag and valid storage: a shadow miss writes the touched (victim) way
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) begin
            for (int w = 0; w < WAYS; w++) begin
               tag_q[r][w]   <= '0;
               valid_q[r][w] <= 1'b0;
            end
         end
      end else if (upd_en && !lk_hit) begin
         tag_q[lk_row][touch_way]   <= lk_tag;
         valid_q[lk_row][touch_way] <= 1'b1;
      end
   end

   generate
      if (WAYS < 1) begin : g_bad_ways
         $error("ctn_shadow_tags: WAYS must be at least 1");
      end

      if (WAYS == 1) begin : g_direct
         assign victim_way = '0;
         always_ff @(posedge clk) begin
            for (int r = 0; r < ROWS; r++) age_q[r][0] <= '0;
         end
      end else begin : g_lru
         logic [AGE_W-1:0] touch_age;
         logic [WAYS-1:0]  oldest_vec;

         // ages form a permutation of 0..WAYS-1; the oldest way is the victim
         always_comb begin
            victim_way = '0;
            for (int w = 0; w < WAYS; w++) begin
               oldest_vec[w] = (age_q[lk_row][w] == AGE_W'(WAYS - 1));
               if (oldest_vec[w]) victim_way = WAY_W'(w);
            end
         end

         assign touch_age = age_q[lk_row][touch_way];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int r = 0; r < ROWS; r++) begin
                  for (int w = 0; w < WAYS; w++) begin
                     age_q[r][w] <= AGE_W'(w);
                  end
               end
            end else if (upd_en) begin
               for (int w = 0; w < WAYS; w++) begin
                  if (WAY_W'(w) == touch_way) begin
                     age_q[lk_row][w] <= '0;
                  end else if (age_q[lk_row][w] < touch_age) begin
                     age_q[lk_row][w] <= age_q[lk_row][w] + AGE_W'(1);
                  end
               end
            end
         end

         // R5: the addressed row always has exactly one least recently used way
         a_r5_single_victim: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(oldest_vec) == 1);
      end
   endgenerate

   // flattened state, used to check that untouched cycles leave it intact
   logic [SNAP_W-1:0] snap;
   always_comb begin
      for (int r = 0; r < ROWS; r++) begin
         for (int w = 0; w < WAYS; w++) begin
            snap[(r*WAYS + w)*SLOT_W +: SLOT_W] = {valid_q[r][w], tag_q[r][w], age_q[r][w]};
         end
      end
   end

   // R4: without an owner access to a sampled set the shadow store holds still
   a_r4_store_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(snap));

   // R5: a shadow hit never rewrites a tag
   a_r5_hit_keeps_tag: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && lk_hit) |=> $stable(lk_hit) || !$stable(lk_row) || !$stable(lk_tag) || lk_hit);

endmodule

// File: rtl/ctn_counter.sv
module ctn_counter #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] raw
);

   localparam logic [CNT_W-1:0] MAX_CNT = '1;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("ctn_counter: CNT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw <= '0;
      end else if (clr) begin
         raw <= inc ? CNT_W'(1) : '0;
      end else if (inc && (raw != MAX_CNT)) begin
         raw <= raw + CNT_W'(1);
      end
   end

   // R7: a strobe leaves at most the one event of its own cycle
   a_r7_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> raw <= CNT_W'(1));

   // R8: between strobes the count never moves down
   a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> raw >= $past(raw));

   // R8: once full it stays full until cleared
   a_r8_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
      (raw == MAX_CNT && !clr) |=> raw == MAX_CNT);

endmodule

// File: rtl/ctn_shadow_detector.sv
module ctn_shadow_detector
   import ctn_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int OFF_W     = 6,
   parameter int SET_W     = 10,
   parameter int WAYS      = 4,
   parameter int SAMP_W    = 5,
   parameter int SAMP_PAT  = 3,
   parameter int APP_W     = 2,
   parameter int OWNER_APP = 0,
   parameter int CNT_W     = 20,
   localparam int TAG_W    = ADDR_W - OFF_W - SET_W,
   localparam int ROW_W    = SET_W - SAMP_W,
   localparam int OUT_W    = CNT_W + SAMP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [APP_W-1:0]  acc_app,
   input  logic              acc_shared_hit,
   input  logic              interval_start,
   output logic              cont_pulse,
   output logic [OUT_W-1:0]  cont_count
);

   generate
      if (TAG_W < 1) begin : g_bad_tag
         $error("ctn_shadow_detector: address too narrow for offset and index");
      end
      if (SAMP_W >= SET_W) begin : g_bad_samp
         $error("ctn_shadow_detector: SAMP_W must be below SET_W");
      end
      if (OWNER_APP >= (1 << APP_W)) begin : g_bad_owner
         $error("ctn_shadow_detector: OWNER_APP does not fit APP_W");
      end
   endgenerate

   logic [TAG_W-1:0] acc_tag;
   logic [ROW_W-1:0] acc_row;
   logic             acc_sampled;
   logic             own_sampled;
   logic             shadow_hit;
   logic             is_cont;
   logic [CNT_W-1:0] raw_cnt;

   ctn_addr_split #(
      .ADDR_W   (ADDR_W),
      .OFF_W    (OFF_W),
      .SET_W    (SET_W),
      .SAMP_W   (SAMP_W),
      .SAMP_PAT (SAMP_PAT)
   ) split_i (
      .addr    (acc_addr),
      .tag     (acc_tag),
      .row     (acc_row),
      .sampled (acc_sampled)
   );

   assign own_sampled = acc_valid && (acc_app == APP_W'(OWNER_APP)) && acc_sampled;

   ctn_shadow_tags #(
      .TAG_W (TAG_W),
      .ROW_W (ROW_W),
      .WAYS  (WAYS)
   ) tags_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .lk_row (acc_row),
      .lk_tag (acc_tag),
      .upd_en (own_sampled),
      .lk_hit (shadow_hit)
   );

   assign is_cont = own_sampled && !acc_shared_hit && shadow_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) cont_pulse <= 1'b0;
      else        cont_pulse <= is_cont;
   end

   ctn_counter #(
      .CNT_W (CNT_W)
   ) cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (interval_start),
      .inc   (is_cont),
      .raw   (raw_cnt)
   );

   // scale the sampled count up to the full set population
   assign cont_count = OUT_W'(raw_cnt) << SAMP_W;

   // R2: a pulse always follows an owner access that missed the shared cache
   a_r2_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      cont_pulse |-> $past(acc_valid && !acc_shared_hit && (acc_app == APP_W'(OWNER_APP))));

   // R3: shared hits are never contention
   a_r3_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_shared_hit) |=> !cont_pulse);

   // R4: foreign applications never produce a pulse
   a_r4_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && (acc_app != APP_W'(OWNER_APP))) |=> !cont_pulse);

   // R9: idle cycles never produce a pulse
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !cont_pulse);

   // R6: without a strobe, each pulse is matched by a count step of one scaled unit
   a_r6_pulse_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (cont_pulse && !$past(interval_start) && ($past(cont_count) != ({OUT_W{1'b1}} << SAMP_W)))
      |-> cont_count == $past(cont_count) + (OUT_W'(1) << SAMP_W));

endmodule

// File: tb/ctn_shadow_detector_tb_top.sv
module ctn_shadow_detector_tb_top;

   localparam int OWNER   = 1;
   localparam int PAT     = 3;
   localparam int CNT_W   = 6;
   localparam int RAW_MAX = (1 << CNT_W) - 1;
   localparam int NROWS   = 32;
   localparam int NWAYS   = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_app = '0;
   logic        acc_shared_hit = 1'b0;
   logic        interval_start = 1'b0;
   logic        cont_pulse;
   logic [10:0] cont_count;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model: per-row list of tags, most recent first
   int m_list [NROWS][NWAYS];
   int m_n    [NROWS];
   int m_raw  = 0;

   always #5 clk = ~clk;

   ctn_shadow_detector #(
      .WAYS      (NWAYS),
      .SAMP_W    (5),
      .SAMP_PAT  (PAT),
      .OWNER_APP (OWNER),
      .CNT_W     (CNT_W)
   ) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .acc_valid      (acc_valid),
      .acc_addr       (acc_addr),
      .acc_app        (acc_app),
      .acc_shared_hit (acc_shared_hit),
      .interval_start (interval_start),
      .cont_pulse     (cont_pulse),
      .cont_count     (cont_count)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic bit m_lookup(input int row, input int tag);
      for (int k = 0; k < m_n[row]; k++) if (m_list[row][k] == tag) return 1'b1;
      return 1'b0;
   endfunction

   function automatic void m_touch(input int row, input int tag);
      int pos;
      pos = -1;
      for (int k = 0; k < m_n[row]; k++) if (m_list[row][k] == tag) pos = k;
      if (pos < 0) begin
         if (m_n[row] < NWAYS) begin
            pos = m_n[row];
            m_n[row]++;
         end else begin
            pos = NWAYS - 1;
         end
      end
      for (int k = pos; k > 0; k--) m_list[row][k] = m_list[row][k-1];
      m_list[row][0] = tag;
   endfunction

   // drive one cycle at a falling edge, predict, check after the rising edge
   task automatic acc(input bit v, input int app, input int tag, input int set,
                      input bit sh, input bit clr, input string req);
      bit own;
      bit ep;
      int row;
      acc_valid      = v;
      acc_app        = 2'(app);
      acc_addr       = {16'(tag), 10'(set), 6'($urandom_range(0, 63))};
      acc_shared_hit = sh;
      interval_start = clr;
      row = set >> 5;
      own = v && (app == OWNER) && ((set % 32) == PAT);
      ep  = own && !sh && m_lookup(row, tag);
      if (own) m_touch(row, tag);
      if (clr) m_raw = ep ? 1 : 0;
      else if (ep && m_raw < RAW_MAX) m_raw++;
      @(posedge clk);
      #2;
      check(cont_pulse === ep, req, "pulse", int'(cont_pulse), int'(ep));
      check(cont_count === 11'(m_raw * 32), req, "count", int'(cont_count), m_raw * 32);
      @(negedge clk);
      acc_valid      = 1'b0;
      interval_start = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int pool [7] = '{3, 35, 67, 99, 4, 36, 100};
      void'($urandom(32'h5eed_c0de));
      for (int r = 0; r < NROWS; r++) m_n[r] = 0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check(cont_pulse === 1'b0, "R1", "pulse", int'(cont_pulse), 0);
      check(cont_count === 11'd0, "R1", "count", int'(cont_count), 0);

      // R1: empty shadow store, first owner miss is not contention
      acc(1, OWNER, 5, 3, 0, 0, "R1");
      // R2 and R6: second shared miss on a tag the shadow holds
      acc(1, OWNER, 5, 3, 0, 0, "R2");
      // R3: shared hit with tag present
      acc(1, OWNER, 5, 3, 1, 0, "R3");
      // R4: foreign app traffic on the same sampled row
      for (int t = 10; t < 14; t++) acc(1, 2, t, 3, 0, 0, "R4");
      acc(1, OWNER, 5, 3, 0, 0, "R4");
      // R4: unsampled set 36 shares row 1 with sampled set 35
      for (int t = 20; t < 25; t++) acc(1, OWNER, t, 36, 0, 0, "R4");
      acc(1, OWNER, 20, 35, 0, 0, "R4");
      // R5: LRU order in row 2 (set 67)
      for (int t = 1; t < 5; t++) acc(1, OWNER, t, 67, 0, 0, "R5");
      acc(1, OWNER, 1, 67, 1, 0, "R5");
      acc(1, OWNER, 5, 67, 0, 0, "R5");
      acc(1, OWNER, 2, 67, 0, 0, "R5");
      acc(1, OWNER, 4, 67, 0, 0, "R5");
      acc(1, OWNER, 3, 67, 0, 0, "R5");
      // R9: idle cycle with a present tag
      acc(0, OWNER, 5, 3, 0, 0, "R9");
      // R7: strobe alone, then strobe colliding with a contention miss
      acc(0, OWNER, 0, 0, 0, 1, "R7");
      acc(1, OWNER, 5, 3, 0, 1, "R7");

      // random mix, mostly owner traffic on a few rows
      for (int i = 0; i < 3000; i++) begin
         int app;
         app = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 3)) : OWNER;
         acc(bit'($urandom_range(0, 7) != 0), app, int'($urandom_range(0, 5)),
             pool[$urandom_range(0, 6)], bit'($urandom_range(0, 2) == 0),
             bit'($urandom_range(0, 199) == 0), "R2");
      end

      // R8: saturation of the count
      acc(1, OWNER, 7, 3, 0, 1, "R8");
      for (int i = 0; i < 70; i++) acc(1, OWNER, 7, 3, 0, 0, "R8");
      check(cont_count === 11'(RAW_MAX * 32), "R8", "saturated", int'(cont_count), RAW_MAX * 32);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule